// File: doc/BRIEF.md
# Synchronizer Mode Controller with Lock Indicator

This block sequences a clock-recovery loop through its operating modes: a timed start-up hold after reset, normal tracking of the reference, automatic freerun when the reference is reported bad, and a phase-realignment step that every recovery passes through before tracking resumes. It tells the oscillator when to keep its last frequency. It enables the clock and frame outputs once the start-up hold has ended. It starts and waits on the external realignment logic.

It also drives the lock status. Lock is granted only after the phase error has stayed inside the lock window for a qualifying number of ticks. When the loop drops into freerun, lock is kept high for a grace period, so that a short reference outage does not toggle the status. All three intervals are counted on a slow `tick` strobe and are set by parameters.

Top module: `sync_mode_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are: `mode` = 2'b00 (start-up), `out_en` = 0, `lock` = 0, `align_start` = 0, `hold_freq` = 0.
- R2: After `rst` falls, `mode` stays 2'b00 with `out_en` low until the edge that samples the RST_TICKS-th `tick` pulse. From that edge `mode` is 2'b01 (normal). `out_en` is high in every mode except 2'b00.
- R3: In normal mode, `ref_bad` high at an edge moves `mode` to 2'b10 (freerun).
- R4: `hold_freq` is high exactly while `mode` is 2'b10 (freerun) or 2'b11 (realign).
- R5: In freerun, `ref_bad` low at an edge moves `mode` to 2'b11. `align_start` is high for the first cycle of realign only and low at all other times.
- R6: In realign, `ref_bad` high at an edge returns `mode` to 2'b10, and this takes priority over `align_done`. Otherwise `align_done` high moves `mode` to 2'b01, and without it the mode stays 2'b11.
- R7: In normal mode, `lock` rises at the edge that samples the QUAL_TICKS-th `tick` of an unbroken run of `phase_in_win` high. The run counts from entry to normal or from the last excursion.
- R8: In normal mode, `phase_in_win` low at an edge clears `lock` and restarts the qualifying count.
- R9: `lock` keeps its value on entry to freerun. It falls at the edge that samples the HOLD_TICKS-th `tick` since that entry if the mode is still freerun. It is unchanged while in realign.
- R10: `ref_bad`, `align_done` and `phase_in_win` have no effect while `mode` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timebase strobe for all timers |
| ref_bad | input | 1 | Reference reported disrupted by the monitor |
| phase_in_win | input | 1 | Phase error is inside the lock window |
| align_done | input | 1 | Realignment logic has finished |
| mode | output | 2 | 00 start-up, 01 normal, 10 freerun, 11 realign |
| out_en | output | 1 | Enable for the clock, frame and status outputs |
| align_start | output | 1 | One-cycle start pulse for the realignment logic |
| hold_freq | output | 1 | Oscillator keeps its last frequency |
| lock | output | 1 | Lock indicator |

## Verification
Every mode change, the `align_start` pulse and every `lock` change is due one clock after the edge that samples its cause, whether that cause is an input level or the final `tick` of a count. `out_en` and `hold_freq` follow `mode` in that same cycle. A behavioural model in the bench steps once per rising edge from the same sampled inputs. Its outputs are compared with the design on every falling edge. Directed checks sample in the falling edge right after a stimulus. Timer checks sample at points that are safely before or after the earliest and latest tick counts that can fall in the window.

// File: rtl/sync_mode_pkg.sv
package sync_mode_pkg;

    typedef enum logic [1:0] {
        MODE_STARTUP = 2'b00,
        MODE_NORMAL  = 2'b01,
        MODE_FREERUN = 2'b10,
        MODE_REALIGN = 2'b11
    } sync_mode_e;

    typedef struct packed {
        logic out_en;
        logic hold_freq;
        logic align_start;
    } mode_ctl_t;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/tick_timer.sv
module tick_timer
    import sync_mode_pkg::*;
#(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tick,
    output logic fire
);
    localparam int unsigned W = cnt_width(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    assign fire = en && tick && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (fire) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
    import sync_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_bad,
    input  logic       align_done,
    input  logic       startup_fire,
    output sync_mode_e state,
    output mode_ctl_t  ctl
);
    sync_mode_e nxt;
    logic       start_q;

    always_comb begin
        nxt = state;
        unique case (state)
            MODE_STARTUP: if (startup_fire) nxt = MODE_NORMAL;
            MODE_NORMAL:  if (ref_bad) nxt = MODE_FREERUN;
            MODE_FREERUN: if (!ref_bad) nxt = MODE_REALIGN;
            MODE_REALIGN: begin
                if (ref_bad)         nxt = MODE_FREERUN;
                else if (align_done) nxt = MODE_NORMAL;
            end
            default: nxt = MODE_STARTUP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= MODE_STARTUP;
            start_q <= 1'b0;
        end else begin
            state   <= nxt;
            start_q <= (state == MODE_FREERUN) && (nxt == MODE_REALIGN);
        end
    end

    always_comb begin
        ctl.out_en      = (state != MODE_STARTUP);
        ctl.hold_freq   = (state == MODE_FREERUN) || (state == MODE_REALIGN);
        ctl.align_start = start_q;
    end
endmodule

// File: rtl/lock_tracker.sv
module lock_tracker
    import sync_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sync_mode_e state,
    input  logic       in_win,
    input  logic       qual_fire,
    input  logic       grace_fire,
    output logic       lock
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lock <= 1'b0;
        end else begin
            unique case (state)
                MODE_STARTUP: lock <= 1'b0;
                MODE_NORMAL: begin
                    if (!in_win)        lock <= 1'b0;
                    else if (qual_fire) lock <= 1'b1;
                end
                MODE_FREERUN: if (grace_fire) lock <= 1'b0;
                default:      lock <= lock;
            endcase
        end
    end
endmodule

// File: rtl/sync_mode_ctrl.sv
module sync_mode_ctrl
    import sync_mode_pkg::*;
#(
    parameter int unsigned RST_TICKS  = 3,
    parameter int unsigned HOLD_TICKS = 100,
    parameter int unsigned QUAL_TICKS = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       ref_bad,
    input  logic       phase_in_win,
    input  logic       align_done,
    output logic [1:0] mode,
    output logic       out_en,
    output logic       align_start,
    output logic       hold_freq,
    output logic       lock
);
    sync_mode_e state;
    mode_ctl_t  ctl;
    logic       startup_fire, grace_fire, qual_fire;
    logic       startup_en, grace_en, qual_en;

    assign startup_en = (state == MODE_STARTUP);
    assign grace_en   = (state == MODE_FREERUN);
    assign qual_en    = (state == MODE_NORMAL) && phase_in_win;

    tick_timer #(.LIMIT(RST_TICKS)) i_startup_tmr (
        .clk(clk), .rst(rst), .en(startup_en), .tick(tick), .fire(startup_fire)
    );

    tick_timer #(.LIMIT(HOLD_TICKS)) i_grace_tmr (
        .clk(clk), .rst(rst), .en(grace_en), .tick(tick), .fire(grace_fire)
    );

    tick_timer #(.LIMIT(QUAL_TICKS)) i_qual_tmr (
        .clk(clk), .rst(rst), .en(qual_en), .tick(tick), .fire(qual_fire)
    );

    mode_fsm i_fsm (
        .clk(clk), .rst(rst), .ref_bad(ref_bad), .align_done(align_done),
        .startup_fire(startup_fire), .state(state), .ctl(ctl)
    );

    lock_tracker i_lock (
        .clk(clk), .rst(rst), .state(state), .in_win(phase_in_win),
        .qual_fire(qual_fire), .grace_fire(grace_fire), .lock(lock)
    );

    assign mode        = state;
    assign out_en      = ctl.out_en;
    assign align_start = ctl.align_start;
    assign hold_freq   = ctl.hold_freq;
endmodule

// File: rtl/sync_mode_ctrl_chk.sv
module sync_mode_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       ref_bad,
    input logic       phase_in_win,
    input logic       align_done,
    input logic [1:0] mode,
    input logic       out_en,
    input logic       align_start,
    input logic       hold_freq,
    input logic       lock
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mode == 2'b00 && !out_en && !lock && !align_start && !hold_freq));

    // R2
    startup_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00) |-> !out_en);

    // R3
    enter_freerun_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && ref_bad) |=> (mode == 2'b10));

    // R5
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10 && !ref_bad) |=> (align_start && mode == 2'b11));

    // R5
    start_once_chk: assert property (@(posedge clk) disable iff (rst)
        align_start |=> !align_start);

    // R6
    realign_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11 && ref_bad) |=> (mode == 2'b10));

    // R8
    window_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && !phase_in_win) |=> !lock);

    // R9
    realign_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11) |=> $stable(lock));

    // R7
    lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lock) |-> ($past(mode) == 2'b01));
endmodule

bind sync_mode_ctrl sync_mode_ctrl_chk i_chk (
    .clk(clk), .rst(rst), .ref_bad(ref_bad), .phase_in_win(phase_in_win),
    .align_done(align_done), .mode(mode), .out_en(out_en),
    .align_start(align_start), .hold_freq(hold_freq), .lock(lock)
);

// File: tb/test_sync_mode_ctrl.sv
`timescale 1ns/1ps
module test_sync_mode_ctrl;
    localparam int RST_T  = 3;
    localparam int HOLD_T = 100;
    localparam int QUAL_T = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic ref_bad = 1'b1;
    logic phase_in_win = 1'b1;
    logic align_done = 1'b1;
    logic [1:0] mode;
    logic out_en, align_start, hold_freq, lock;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sync_mode_ctrl #(.RST_TICKS(RST_T), .HOLD_TICKS(HOLD_T), .QUAL_TICKS(QUAL_T)) i_sync_mode_ctrl (
        .clk(clk), .rst(rst), .tick(tick), .ref_bad(ref_bad),
        .phase_in_win(phase_in_win), .align_done(align_done), .mode(mode),
        .out_en(out_en), .align_start(align_start), .hold_freq(hold_freq), .lock(lock)
    );

    // timebase: one tick in every four cycles
    int tdiv = 0;
    always @(negedge clk) begin
        tick <= (tdiv == 3);
        tdiv = (tdiv + 1) % 4;
    end

    // behavioural reference model
    int m_mode = 0, m_rc = 0, m_hc = 0, m_qc = 0;
    bit m_lock = 0, m_start = 0, m_valid = 0;
    always @(posedge clk) begin
        int nm;
        if (rst) begin
            m_mode = 0; m_rc = 0; m_hc = 0; m_qc = 0; m_lock = 0; m_start = 0; m_valid = 1;
        end else begin
            nm = m_mode;
            m_start = 0;
            case (m_mode)
                0: if (tick) begin
                       m_rc++;
                       if (m_rc == RST_T) begin nm = 1; m_rc = 0; end
                   end
                1: begin
                       if (!phase_in_win) begin m_qc = 0; m_lock = 0; end
                       else if (tick) begin
                           m_qc++;
                           if (m_qc == QUAL_T) begin m_lock = 1; m_qc = 0; end
                       end
                       if (ref_bad) begin nm = 2; m_hc = 0; m_qc = 0; end
                   end
                2: begin
                       if (tick) begin
                           m_hc++;
                           if (m_hc == HOLD_T) begin m_lock = 0; m_hc = 0; end
                       end
                       if (!ref_bad) begin nm = 3; m_start = 1; end
                   end
                default: begin
                       if (ref_bad) begin nm = 2; m_hc = 0; end
                       else if (align_done) begin nm = 1; m_qc = 0; end
                   end
            endcase
            m_mode = nm;
        end
    end

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (m_valid && !finished) begin
            check(int'(mode), m_mode, "R3 model mode");
            check(int'(out_en), int'(m_mode != 0), "R2 model out_en");
            check(int'(hold_freq), int'(m_mode >= 2), "R4 model hold_freq");
            check(int'(align_start), int'(m_start), "R5 model align_start");
            check(int'(lock), int'(m_lock), "R7 model lock");
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_mode(input int want, input string tag);
        for (int i = 0; i < 60; i++) begin
            if (int'(mode) == want) break;
            @(negedge clk);
        end
        check(int'(mode), want, tag);
    endtask

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        cycles(5);
        // R1
        check(int'(mode), 0, "R1 mode in reset");
        check(int'(out_en), 0, "R1 out_en in reset");
        check(int'(lock), 0, "R1 lock in reset");
        rst = 1'b0;
        for (int i = 0; i < 6; i++) begin
            cycles(1);
            // R10: ref_bad, align_done, phase_in_win all high during start-up
            check(int'(mode), 0, "R10 start-up ignores inputs");
            check(int'(out_en), 0, "R2 out_en low in start-up");
        end
        ref_bad = 1'b0;
        align_done = 1'b0;
        wait_mode(1, "R2 normal after start-up");
        check(int'(out_en), 1, "R2 out_en in normal");
        check(int'(hold_freq), 0, "R4 no hold in normal");

        cycles(40);
        check(int'(lock), 0, "R7 lock not yet qualified");
        phase_in_win = 1'b0;
        cycles(1);
        check(int'(lock), 0, "R8 lock low on excursion");
        phase_in_win = 1'b1;
        cycles(70);
        check(int'(lock), 0, "R8 qualifying restarted");
        cycles(20);
        check(int'(lock), 1, "R7 lock after qualifying");

        ref_bad = 1'b1;
        cycles(1);
        check(int'(mode), 2, "R3 freerun on bad ref");
        check(int'(hold_freq), 1, "R4 hold in freerun");
        check(int'(lock), 1, "R9 lock kept on freerun entry");
        cycles(30);
        check(int'(lock), 1, "R9 lock within grace");
        ref_bad = 1'b0;
        cycles(1);
        check(int'(mode), 3, "R5 realign on recovery");
        check(int'(align_start), 1, "R5 start pulse");
        check(int'(hold_freq), 1, "R4 hold in realign");
        cycles(1);
        check(int'(align_start), 0, "R5 start pulse one cycle");
        check(int'(mode), 3, "R6 waits for done");
        cycles(8);
        check(int'(lock), 1, "R9 lock unchanged in realign");
        align_done = 1'b1;
        cycles(1);
        check(int'(mode), 1, "R6 normal after done");
        align_done = 1'b0;

        ref_bad = 1'b1;
        cycles(380);
        check(int'(lock), 1, "R9 lock before grace ends");
        cycles(40);
        check(int'(lock), 0, "R9 lock low after grace");
        check(int'(mode), 2, "R3 still freerun");

        ref_bad = 1'b0;
        cycles(1);
        check(int'(mode), 3, "R5 realign again");
        ref_bad = 1'b1;
        align_done = 1'b1;
        cycles(1);
        check(int'(mode), 2, "R6 bad ref beats done");
        ref_bad = 1'b0;
        cycles(1);
        check(int'(align_start), 1, "R5 start pulse again");
        cycles(1);
        check(int'(mode), 1, "R6 done taken in first cycle");
        align_done = 1'b0;
        check(int'(lock), 0, "R7 lock must requalify");
        cycles(100);
        check(int'(lock), 1, "R7 lock requalified");

        rst = 1'b1;
        cycles(1);
        check(int'(mode), 0, "R1 mode after mid-run reset");
        check(int'(lock), 0, "R1 lock after mid-run reset");
        check(int'(out_en), 0, "R1 out_en after mid-run reset");
        rst = 1'b0;
        wait_mode(1, "R2 restart to normal");
        cycles(4);
        finished = 1;
        report();
    end

    initial begin
        #800000;
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end
endmodule